// File: doc/BRIEF.md
# Four-Stage Pipeline Hazard and Operand Forwarding Control

This block is the interlock controller of an in-order processor pipeline with four stages: fetch, register read, ALU and write-back. It follows the register numbers and write-enables of the instructions in the register-read, ALU and write-back stages. For each source operand of the instruction in register read, it checks whether an older instruction that has not yet reached the register file is about to write that register. It carries the control fields of each stage in its own pipeline registers. The register file, the ALU and the memories are not part of it.

A synthesis-time parameter picks how a read-after-write conflict is settled. With forwarding, each source operand gets a select code that steers the operand multiplexer to the register file, the ALU result or the write-back value, and the pipeline never waits. With freezing, the fetch and register-read stages hold and a bubble enters the ALU stage for every cycle the conflict lasts. The register file is assumed to write before it reads within a cycle, so no conflict remains once the writer has left write-back. Register 31 always reads as zero and is never a conflict.

Decoded instructions arrive on a valid/ready stream. The block drops `in_ready` in exactly the cycles it freezes. While `in_valid` is high and `in_ready` is low, the sender must hold the word stable. The word is taken on the first rising edge at which both are high, and it is taken only once.

Top module: `hazard_ctl`

## Requirements
- R1: An instruction taken at a clock edge sits in register read for the following cycle. Unless it is held there, it moves to the ALU stage one cycle later and to write-back one cycle after that, where `wb_valid`, `wb_we` and `wb_dst` show it.
- R2: Each source operand has a 2-bit select: 0 means register file, 1 means ALU-stage result, 2 means write-back value, and 3 is never produced. With forwarding, a source that matches the destination of a writing instruction in the ALU stage selects 1.
- R3: With forwarding, a source that matches only the writer in write-back selects 2. A writer three or more instructions older gives select 0.
- R4: When the ALU-stage writer and the write-back writer both target a source register, the ALU stage, being the younger, wins and the select is 1.
- R5: A writer whose destination is register 31, or whose write-enable is low, never causes a match. The select stays 0 and no freeze occurs.
- R6: With freezing, a dependence on the immediately preceding instruction costs exactly 2 freeze cycles. A dependence two instructions back costs 1 cycle, and a dependence further back costs none.
- R7: In every freeze cycle `stall_fetch`, `stall_read` and `nop_ins` are high. The instruction in register read is held, and the ALU stage receives a bubble with its write-enable cleared.
- R8: With forwarding the block never freezes. With freezing both selects always stay 0.
- R9: After reset the pipeline is empty: `in_ready` is high, the freeze and bubble outputs are low, both selects are 0 and `wb_valid` and `wb_we` are low.
- R10: `in_ready` is low exactly in freeze cycles. A held word is taken once when ready returns, and every taken instruction with its write-enable set produces exactly one `wb_we` pulse, with no extra pulse from bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Decoded instruction offered by fetch |
| in_ready | output | 1 | Block takes the instruction this cycle |
| in_src_a | input | 5 | First source register number |
| in_src_b | input | 5 | Second source register number |
| in_dst | input | 5 | Destination register number |
| in_we | input | 1 | Instruction writes its destination |
| sel_a | output | 2 | Operand A select: 0 register file, 1 ALU, 2 write-back |
| sel_b | output | 2 | Operand B select, same coding |
| stall_fetch | output | 1 | Freeze the fetch stage |
| stall_read | output | 1 | Freeze the register-read stage |
| nop_ins | output | 1 | Load a bubble into the ALU instruction register |
| wb_valid | output | 1 | Write-back stage holds a real instruction |
| wb_we | output | 1 | Write-back stage writes the register file |
| wb_dst | output | 5 | Register written at write-back |

## Verification
Every cycle, the assertions check the following. The register-read contents stay put while frozen, and the ALU stage holds no writer after a bubble. A freeze caused by the adjacent instruction carries into the next cycle. Register 31 never selects a forwarded value, the ALU stage wins under forwarding, the reserved select code never appears, and a writing instruction that leaves register read reaches write-back. The exact number of freeze cycles for each dependence distance, the select value for each distance and operand, the timing of write-back and the one-to-one count of write pulses depend on whole instruction sequences. Only the bench sweeps over registers, distances and operand choices show those, in both resolution modes.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned REG_W = 5;
  localparam int unsigned N_SRC = 2;
  localparam int unsigned SEL_W = 2;

  typedef struct packed {
    logic             vld;
    logic             we;
    logic [REG_W-1:0] rd;
  } stage_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF  = 2'd0,
    SEL_ALU = 2'd1,
    SEL_WB  = 2'd2
  } sel_e;
endpackage

// File: rtl/hz_stages.sv
module hz_stages
  import hz_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             stall,
  input  logic [REG_W-1:0] in_ra,
  input  logic [REG_W-1:0] in_rb,
  input  logic [REG_W-1:0] in_rd,
  input  logic             in_we,
  output stage_t           rf_q,
  output logic [REG_W-1:0] rf_ra_q,
  output logic [REG_W-1:0] rf_rb_q,
  output stage_t           alu_q,
  output stage_t           wb_q
);
  localparam logic [REG_W-1:0] ZERO_REG = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_q    <= '0;
      rf_ra_q <= '0;
      rf_rb_q <= '0;
      alu_q   <= '0;
      wb_q    <= '0;
    end else begin
      wb_q <= alu_q;
      if (stall) begin
        // bubble: not valid, write-enable clear; register-read stage held
        alu_q <= '0;
      end else begin
        alu_q <= rf_q;
        if (take) begin
          rf_q    <= '{vld: 1'b1, we: in_we, rd: in_rd};
          rf_ra_q <= in_ra;
          rf_rb_q <= in_rb;
        end else begin
          rf_q    <= '0;
          rf_ra_q <= ZERO_REG;
          rf_rb_q <= ZERO_REG;
        end
      end
    end
  end
endmodule

// File: rtl/hz_match.sv
module hz_match
  import hz_pkg::*;
(
  input  logic             rf_vld,
  input  logic [REG_W-1:0] src,
  input  logic             alu_we,
  input  logic [REG_W-1:0] alu_rd,
  input  logic             wb_we,
  input  logic [REG_W-1:0] wb_rd,
  output logic             hit_alu,
  output logic             hit_wb
);
  localparam logic [REG_W-1:0] ZERO_REG = '1;

  always_comb begin
    hit_alu = rf_vld && alu_we && (alu_rd != ZERO_REG) && (alu_rd == src);
    hit_wb  = rf_vld && wb_we  && (wb_rd  != ZERO_REG) && (wb_rd  == src);
  end
endmodule

// File: rtl/hz_resolve.sv
module hz_resolve
  import hz_pkg::*;
#(
  parameter bit BYPASS = 1'b1
) (
  input  logic [N_SRC-1:0]            hit_alu,
  input  logic [N_SRC-1:0]            hit_wb,
  output logic [N_SRC-1:0][SEL_W-1:0] sel,
  output logic                        stall
);
  if (BYPASS) begin : g_fwd
    always_comb begin
      stall = 1'b0;
      for (int i = 0; i < N_SRC; i++) begin
        if (hit_alu[i])     sel[i] = SEL_ALU;
        else if (hit_wb[i]) sel[i] = SEL_WB;
        else                sel[i] = SEL_RF;
      end
    end
  end else begin : g_frz
    always_comb begin
      stall = (|hit_alu) || (|hit_wb);
      for (int i = 0; i < N_SRC; i++) sel[i] = SEL_RF;
    end
  end
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hz_pkg::*;
#(
  parameter bit BYPASS = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [REG_W-1:0] in_src_a,
  input  logic [REG_W-1:0] in_src_b,
  input  logic [REG_W-1:0] in_dst,
  input  logic             in_we,
  output logic [SEL_W-1:0] sel_a,
  output logic [SEL_W-1:0] sel_b,
  output logic             stall_fetch,
  output logic             stall_read,
  output logic             nop_ins,
  output logic             wb_valid,
  output logic             wb_we,
  output logic [REG_W-1:0] wb_dst
);
  stage_t           rf_q, alu_q, wb_q;
  logic [REG_W-1:0] rf_ra_q, rf_rb_q;
  logic             stall;
  logic             take;
  logic [N_SRC-1:0]            hit_alu, hit_wb;
  logic [N_SRC-1:0][REG_W-1:0] srcs;
  logic [N_SRC-1:0][SEL_W-1:0] sel;

  assign take = in_valid && !stall;

  hz_stages u_stages (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .stall   (stall),
    .in_ra   (in_src_a),
    .in_rb   (in_src_b),
    .in_rd   (in_dst),
    .in_we   (in_we),
    .rf_q    (rf_q),
    .rf_ra_q (rf_ra_q),
    .rf_rb_q (rf_rb_q),
    .alu_q   (alu_q),
    .wb_q    (wb_q)
  );

  assign srcs[0] = rf_ra_q;
  assign srcs[1] = rf_rb_q;

  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_src
    hz_match u_match (
      .rf_vld  (rf_q.vld),
      .src     (srcs[gi]),
      .alu_we  (alu_q.we),
      .alu_rd  (alu_q.rd),
      .wb_we   (wb_q.we),
      .wb_rd   (wb_q.rd),
      .hit_alu (hit_alu[gi]),
      .hit_wb  (hit_wb[gi])
    );
  end

  hz_resolve #(.BYPASS(BYPASS)) u_resolve (
    .hit_alu (hit_alu),
    .hit_wb  (hit_wb),
    .sel     (sel),
    .stall   (stall)
  );

  assign in_ready    = !stall;
  assign sel_a       = sel[0];
  assign sel_b       = sel[1];
  assign stall_fetch = stall;
  assign stall_read  = stall;
  assign nop_ins     = stall;
  assign wb_valid    = wb_q.vld;
  assign wb_we       = wb_q.we;
  assign wb_dst      = wb_q.rd;
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk
  import hz_pkg::*;
#(
  parameter bit BYPASS = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall_read,
  input logic             nop_ins,
  input logic [SEL_W-1:0] sel_a,
  input logic [SEL_W-1:0] sel_b,
  input logic             wb_we,
  input logic             rf_vld,
  input logic             rf_we,
  input logic [REG_W-1:0] rf_ra,
  input logic [REG_W-1:0] rf_rb,
  input logic             alu_we,
  input logic [REG_W-1:0] alu_rd
);
  localparam logic [REG_W-1:0] ZERO_REG = '1;
  logic adj_a, adj_b;
  assign adj_a = rf_vld && alu_we && (alu_rd != ZERO_REG) && (alu_rd == rf_ra);
  assign adj_b = rf_vld && alu_we && (alu_rd != ZERO_REG) && (alu_rd == rf_rb);

  p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_vld && rf_we && !stall_read) |=> ##1 wb_we);

  p_sel_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a != 2'd3) && (sel_b != 2'd3));

  p_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((BYPASS != 1'b0) && adj_a) |-> (sel_a == 2'd1));

  p_zero_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_ra == ZERO_REG) |-> (sel_a == 2'd0));

  p_adj_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((BYPASS == 1'b0) && stall_read && (adj_a || adj_b)) |=> stall_read);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_read |=> (rf_vld && $stable(rf_ra) && $stable(rf_rb)));

  p_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nop_ins |=> !alu_we);

  p_no_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (BYPASS != 1'b0) |-> !stall_read);
endmodule

bind hazard_ctl hazard_ctl_chk #(.BYPASS(BYPASS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stall_read (stall_read),
  .nop_ins    (nop_ins),
  .sel_a      (sel_a),
  .sel_b      (sel_b),
  .wb_we      (wb_we),
  .rf_vld     (rf_q.vld),
  .rf_we      (rf_q.we),
  .rf_ra      (rf_ra_q),
  .rf_rb      (rf_rb_q),
  .alu_we     (alu_q.we),
  .alu_rd     (alu_q.rd)
);

// File: tb/hazard_ctl_tb.sv
module hazard_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] RZ = 5'd31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // index 1: forwarding, index 0: freezing
  logic       in_valid [2];
  logic [4:0] in_ra [2], in_rb [2], in_rd [2];
  logic       in_we [2];
  logic       in_ready [2];
  logic [1:0] sel_a [2], sel_b [2];
  logic       stall_fetch [2], stall_read [2], nop_ins [2];
  logic       wb_valid [2], wb_we [2];
  logic [4:0] wb_dst [2];

  for (genvar gi = 0; gi < 2; gi++) begin : g_m
    hazard_ctl #(.BYPASS(gi == 1)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid[gi]), .in_ready(in_ready[gi]),
      .in_src_a(in_ra[gi]), .in_src_b(in_rb[gi]), .in_dst(in_rd[gi]), .in_we(in_we[gi]),
      .sel_a(sel_a[gi]), .sel_b(sel_b[gi]),
      .stall_fetch(stall_fetch[gi]), .stall_read(stall_read[gi]), .nop_ins(nop_ins[gi]),
      .wb_valid(wb_valid[gi]), .wb_we(wb_we[gi]), .wb_dst(wb_dst[gi])
    );
  end

  int n_chk = 0;
  int n_fail = 0;
  int wb_cnt [2];
  int sent_w [2];
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int m = 0; m < 2; m++) if (wb_we[m]) wb_cnt[m]++;
    end
  end

  // called at a negedge; returns at the negedge of the word's first register-read cycle
  task automatic send(input int m, input logic [4:0] ra, input logic [4:0] rb,
                      input logic [4:0] rd, input logic we);
    in_ra[m] = ra; in_rb[m] = rb; in_rd[m] = rd; in_we[m] = we; in_valid[m] = 1'b1;
    while (!in_ready[m]) @(negedge clk);
    @(posedge clk);
    if (we) sent_w[m]++;
    @(negedge clk);
    in_valid[m] = 1'b0;
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  // count freeze cycles from the current negedge; R7 checked in each
  task automatic count_freeze(input int m, output int n);
    n = 0;
    while (stall_read[m]) begin
      check(stall_fetch[m] && nop_ins[m] && !in_ready[m], "R7 freeze outputs", int'(in_ready[m]), 0);
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      in_valid[m] = 1'b0; in_ra[m] = RZ; in_rb[m] = RZ; in_rd[m] = RZ; in_we[m] = 1'b0;
      wb_cnt[m] = 0; sent_w[m] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    for (int m = 0; m < 2; m++) begin
      check(in_ready[m] && !stall_fetch[m] && !stall_read[m] && !nop_ins[m],
            "R9 controls after reset", int'(in_ready[m]), 1);
      check(sel_a[m] == 2'd0 && sel_b[m] == 2'd0, "R9 selects after reset", int'(sel_a[m]), 0);
      check(!wb_valid[m] && !wb_we[m], "R9 write-back empty", int'(wb_we[m]), 0);
    end

    // R1 stage timing
    for (int m = 0; m < 2; m++) begin
      send(m, RZ, RZ, 5'd7, 1'b1);
      @(negedge clk);
      check(!wb_we[m], "R1 not yet at write-back", int'(wb_we[m]), 0);
      @(negedge clk);
      check(wb_valid[m] && wb_we[m] && wb_dst[m] == 5'd7, "R1 write-back two cycles later",
            int'(wb_dst[m]), 7);
      @(negedge clk);
      check(!wb_we[m], "R1 single write-back cycle", int'(wb_we[m]), 0);
      drain();
    end

    // R2 R3 R5 R6 R8 sweep: register x distance x operand choice x mode
    for (int m = 0; m < 2; m++) begin
      for (int x = 0; x < 32; x++) begin
        for (int gap = 0; gap < 4; gap++) begin
          for (int which = 1; which < 4; which++) begin
            logic [4:0] ra, rb;
            int exp_sel, exp_frz, n;
            bit real_hit;
            real_hit = (x != 31);
            ra = which[0] ? 5'(x) : RZ;
            rb = which[1] ? 5'(x) : RZ;
            if (!real_hit) exp_sel = 0;
            else if (gap == 0) exp_sel = 1;
            else if (gap == 1) exp_sel = 2;
            else exp_sel = 0;
            exp_frz = (real_hit && gap < 2) ? (2 - gap) : 0;
            if (m == 0) exp_sel = 0;
            if (m == 1) exp_frz = 0;
            send(m, RZ, RZ, 5'(x), 1'b1);
            for (int f = 0; f < gap; f++) send(m, RZ, RZ, 5'd3, 1'b0);
            send(m, ra, rb, 5'd4, 1'b0);
            check(sel_a[m] == (which[0] ? 2'(exp_sel) : 2'd0),
                  (m == 1) ? "R2/R3/R5 select A forwarding" : "R8 select A freezing",
                  int'(sel_a[m]), which[0] ? exp_sel : 0);
            check(sel_b[m] == (which[1] ? 2'(exp_sel) : 2'd0),
                  (m == 1) ? "R2/R3/R5 select B forwarding" : "R8 select B freezing",
                  int'(sel_b[m]), which[1] ? exp_sel : 0);
            count_freeze(m, n);
            check(n == exp_frz, (m == 1) ? "R8 no freeze when forwarding" : "R6 freeze cycles",
                  n, exp_frz);
            drain();
          end
        end
      end
    end

    // R5 disabled write-enable never matches
    for (int m = 0; m < 2; m++) begin
      int n;
      send(m, RZ, RZ, 5'd9, 1'b0);
      send(m, 5'd9, 5'd9, 5'd4, 1'b0);
      check(sel_a[m] == 2'd0 && sel_b[m] == 2'd0, "R5 write-enable low", int'(sel_a[m]), 0);
      count_freeze(m, n);
      check(n == 0, "R5 no freeze on write-enable low", n, 0);
      drain();
    end

    // R4 ALU stage wins over write-back
    for (int m = 0; m < 2; m++) begin
      int n;
      send(m, RZ, RZ, 5'd12, 1'b1);
      send(m, RZ, RZ, 5'd12, 1'b1);
      send(m, 5'd12, RZ, 5'd4, 1'b0);
      check(sel_a[m] == ((m == 1) ? 2'd1 : 2'd0), "R4 younger writer wins",
            int'(sel_a[m]), (m == 1) ? 1 : 0);
      count_freeze(m, n);
      check(n == ((m == 1) ? 0 : 2), "R4/R6 freeze with two writers", n, (m == 1) ? 0 : 2);
      drain();
      // mixed: A from write-back, B from ALU
      send(m, RZ, RZ, 5'd13, 1'b1);
      send(m, RZ, RZ, 5'd14, 1'b1);
      send(m, 5'd13, 5'd14, 5'd4, 1'b0);
      if (m == 1) begin
        check(sel_a[m] == 2'd2, "R3 A from write-back", int'(sel_a[m]), 2);
        check(sel_b[m] == 2'd1, "R2 B from ALU", int'(sel_b[m]), 1);
      end
      count_freeze(m, n);
      drain();
    end

    // R10 back-to-back dependent chain, held word taken once, write pulses one-to-one
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 6; k++) send(m, 5'(k), 5'(k), 5'(k + 1), 1'b1);
      drain();
      drain();
      check(wb_cnt[m] == sent_w[m], "R10 one write-back per writer", wb_cnt[m], sent_w[m]);
      check(in_ready[m], "R10 ready after drain", int'(in_ready[m]), 1);
    end

    done = 1'b1;
    report();
  end
endmodule